// File: doc/BRIEF.md
# Static Branch Predictor with One-Step Recovery

This block sits beside the fetch stage and makes a guess for every conditional branch whose outcome is not yet known. A two-bit policy input picks how the guess is formed. It can always guess not-taken. It can look the branch's opcode class up in a fixed table set by a parameter. It can treat a backward branch (negative displacement) as taken. It can follow a predict bit that the compiler placed in the instruction. In every policy the block works out both the fall-through address and the branch target in the same cycle. It drives the address of the path it guessed to fetch as the next PC.

When it accepts a branch, the block stores both addresses and the guess. Only one branch may be in flight. A second branch that reaches fetch while the first is unresolved stalls fetch until the first resolves. The execute stage later reports the real outcome on a resolve strobe. If the outcome matches the guess, the stored addresses are dropped and nothing else happens. If it does not match, the block raises a flush for one cycle and drives the stored address of the other path as the redirect PC, so fetch can restart there at once.

Top module: `static_branch_predictor`

## Requirements
- R1: After reset, flush and fetch_stall are 0 and no branch is in flight.
- R2: With policy_sel = 2'b00 (fixed not-taken), a presented branch gives pred_taken = 0 and pred_npc = br_pc + 4.
- R3: With policy_sel = 2'b10 (displacement sign), the guess is taken exactly when bit 11 (the sign bit) of br_disp is 1. A taken guess gives pred_npc = br_pc + sign-extended br_disp.
- R4: With policy_sel = 2'b01 (opcode table), the guess is taken exactly when bit br_opc of the table parameter is 1. The default table is 8'hA5, so classes 0, 2, 5 and 7 are taken.
- R5: With policy_sel = 2'b11 (compiler hint), the guess equals br_hint.
- R6: While a branch is in flight, a newly presented branch raises fetch_stall in the same cycle and is not recorded. The next resolve applies to the earlier branch.
- R7: A resolve whose outcome matches the stored guess clears the in-flight branch and raises no flush.
- R8: A resolve whose outcome differs from the stored guess raises flush in the next cycle for exactly one cycle. In that cycle redirect_pc is the stored target if the real outcome was taken, and the stored fall-through address if it was not.
- R9: A resolve strobe that arrives while no branch is in flight is ignored and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A conditional branch is at fetch this cycle |
| br_pc | input | 32 | Address of the branch |
| br_opc | input | 3 | Opcode class of the branch |
| br_disp | input | 12 | Signed byte displacement to the target |
| br_hint | input | 1 | Compiler predict bit (1 = taken) |
| policy_sel | input | 2 | Guess policy: 00 fixed, 01 opcode, 10 sign, 11 hint |
| res_valid | input | 1 | Outcome strobe from execute |
| res_taken | input | 1 | Real outcome carried by the strobe |
| pred_taken | output | 1 | Guess for the presented branch |
| pred_npc | output | 32 | Next fetch address on the guessed path |
| fetch_stall | output | 1 | Hold fetch: a branch is already in flight |
| flush | output | 1 | Discard speculative work (one cycle) |
| redirect_pc | output | 32 | Restart address, valid while flush is 1 |

## Verification
A corrupted in-flight flag shows up at the ports at the next branch or resolve. A wrong stall appears in the same cycle as the second branch, and a missing or spurious flush appears one cycle after the strobe. Corrupted stored addresses or a corrupted stored guess stay hidden until the branch resolves against its guess. They then show in that flush cycle as a wrong redirect_pc or a wrong flush decision. For that reason the bench resolves many branches in both directions, under all four policies.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    POL_FIXED_NT = 2'b00,
    POL_OPCODE   = 2'b01,
    POL_DISP     = 2'b10,
    POL_HINT     = 2'b11
  } policy_e;

endpackage

// File: rtl/sbp_policy.sv
module sbp_policy
  import sbp_pkg::*;
#(
  parameter int                OPC_W          = 3,
  parameter int                DISP_W         = 12,
  parameter logic [(1<<OPC_W)-1:0] OPC_TAKEN_MASK = 8'hA5
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DISP_W-1:0] disp,
  input  logic              hint,
  input  logic [1:0]        policy_sel,
  output logic              guess
);

  localparam int NUM_OPC = 1 << OPC_W;

  logic [NUM_OPC-1:0] opc_tbl;

  // one table entry per opcode class
  for (genvar g = 0; g < NUM_OPC; g++) begin : g_tbl
    assign opc_tbl[g] = OPC_TAKEN_MASK[g];
  end

  always_comb begin
    unique case (policy_e'(policy_sel))
      POL_FIXED_NT: guess = 1'b0;
      POL_OPCODE:   guess = opc_tbl[opc];
      POL_DISP:     guess = disp[DISP_W-1];
      POL_HINT:     guess = hint;
      default:      guess = 1'b0;
    endcase
  end

endmodule

// File: rtl/sbp_addr_gen.sv
module sbp_addr_gen #(
  parameter int PC_W        = 32,
  parameter int DISP_W      = 12,
  parameter int INSTR_BYTES = 4
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [PC_W-1:0] disp_ext;

  assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign seq_pc   = pc + STEP;
  assign tgt_pc   = pc + disp_ext;

endmodule

// File: rtl/sbp_recovery.sv
module sbp_recovery #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            guess,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] tgt_pc,
  input  logic            res_valid,
  input  logic            res_taken,
  output logic            pending,
  output logic            flush,
  output logic [PC_W-1:0] redirect_pc
);

  logic            pend_q, pend_n;
  logic            guess_q;
  logic [PC_W-1:0] seq_q, tgt_q;
  logic            flush_q, flush_n;
  logic [PC_W-1:0] redir_q, redir_n;
  logic            save_en;
  logic            mismatch;

  assign save_en  = cap_en && !pend_q;
  assign mismatch = pend_q && res_valid && (res_taken != guess_q);

  always_comb begin
    pend_n  = pend_q;
    flush_n = 1'b0;
    redir_n = redir_q;
    if (pend_q) begin
      if (res_valid) begin
        pend_n = 1'b0;
      end
    end else if (cap_en) begin
      pend_n = 1'b1;
    end
    if (mismatch) begin
      flush_n = 1'b1;
      redir_n = res_taken ? tgt_q : seq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      flush_q <= flush_n;
    end
  end

  // both alternate addresses saved when a branch is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guess_q <= 1'b0;
      seq_q   <= '0;
      tgt_q   <= '0;
    end else if (save_en) begin
      guess_q <= guess;
      seq_q   <= seq_pc;
      tgt_q   <= tgt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= '0;
    end else if (mismatch) begin
      redir_q <= redir_n;
    end
  end

  assign pending     = pend_q;
  assign flush       = flush_q;
  assign redirect_pc = redir_q;

  p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(res_valid) && !pending);

  p_idle_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !pending) |=> !flush);

  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && pending && !res_valid) |=> pending && $stable(seq_q) && $stable(tgt_q));

endmodule

// File: rtl/static_branch_predictor.sv
module static_branch_predictor
  import sbp_pkg::*;
#(
  parameter int                    PC_W           = 32,
  parameter int                    DISP_W         = 12,
  parameter int                    OPC_W          = 3,
  parameter int                    INSTR_BYTES    = 4,
  parameter logic [(1<<OPC_W)-1:0] OPC_TAKEN_MASK = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [PC_W-1:0]   br_pc,
  input  logic [OPC_W-1:0]  br_opc,
  input  logic [DISP_W-1:0] br_disp,
  input  logic              br_hint,
  input  logic [1:0]        policy_sel,
  input  logic              res_valid,
  input  logic              res_taken,
  output logic              pred_taken,
  output logic [PC_W-1:0]   pred_npc,
  output logic              fetch_stall,
  output logic              flush,
  output logic [PC_W-1:0]   redirect_pc
);

  logic            guess;
  logic [PC_W-1:0] seq_pc, tgt_pc;
  logic            pending;

  sbp_policy #(
    .OPC_W          (OPC_W),
    .DISP_W         (DISP_W),
    .OPC_TAKEN_MASK (OPC_TAKEN_MASK)
  ) u_policy (
    .opc        (br_opc),
    .disp       (br_disp),
    .hint       (br_hint),
    .policy_sel (policy_sel),
    .guess      (guess)
  );

  sbp_addr_gen #(
    .PC_W        (PC_W),
    .DISP_W      (DISP_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_addr (
    .pc     (br_pc),
    .disp   (br_disp),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  sbp_recovery #(
    .PC_W (PC_W)
  ) u_recov (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (br_valid),
    .guess       (guess),
    .seq_pc      (seq_pc),
    .tgt_pc      (tgt_pc),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .pending     (pending),
    .flush       (flush),
    .redirect_pc (redirect_pc)
  );

  assign pred_taken  = br_valid && guess;
  assign pred_npc    = guess ? tgt_pc : seq_pc;
  assign fetch_stall = br_valid && pending;

  p_fixed_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && policy_sel == 2'b00) |-> !pred_taken &&
      pred_npc == br_pc + PC_W'(INSTR_BYTES));

  p_back_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && policy_sel == 2'b10 && br_disp[DISP_W-1]) |->
      pred_taken && pred_npc == br_pc + {{(PC_W-DISP_W){1'b1}}, br_disp});

  p_hint_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && policy_sel == 2'b11) |-> pred_taken == br_hint);

endmodule

// File: tb/static_branch_predictor_tb_top.sv
`timescale 1ns/1ps
module static_branch_predictor_tb_top;

  localparam logic [7:0] MASK = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [31:0] br_pc;
  logic [2:0]  br_opc;
  logic [11:0] br_disp;
  logic        br_hint;
  logic [1:0]  policy_sel;
  logic        res_valid;
  logic        res_taken;
  logic        pred_taken;
  logic [31:0] pred_npc;
  logic        fetch_stall;
  logic        flush;
  logic [31:0] redirect_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  bit          m_pend = 1'b0;
  bit          m_guess = 1'b0;
  logic [31:0] m_seq = '0, m_tgt = '0;
  bit          m_flush = 1'b0;
  logic [31:0] m_redir = '0;
  string       m_ftag = "R1";

  always #4 clk = ~clk;

  static_branch_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .br_opc(br_opc), .br_disp(br_disp), .br_hint(br_hint),
    .policy_sel(policy_sel), .res_valid(res_valid), .res_taken(res_taken),
    .pred_taken(pred_taken), .pred_npc(pred_npc), .fetch_stall(fetch_stall),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  function automatic bit exp_guess(logic [1:0] pol, logic [2:0] opc,
                                   logic [11:0] disp, logic hint);
    case (pol)
      2'b00:   return 1'b0;
      2'b01:   return MASK[opc];
      2'b10:   return disp[11];
      default: return hint;
    endcase
  endfunction

  function automatic string pol_tag(logic [1:0] pol);
    case (pol)
      2'b00:   return "R2";
      2'b01:   return "R4";
      2'b10:   return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit bv, logic [1:0] pol, logic [31:0] pc, logic [2:0] opc,
                      logic [11:0] disp, bit hint, bit rv, bit rt);
    bit          g;
    logic [31:0] seq, tgt, npc;
    @(negedge clk);
    br_valid = bv; policy_sel = pol; br_pc = pc; br_opc = opc;
    br_disp = disp; br_hint = hint; res_valid = rv; res_taken = rt;
    #1;
    g   = exp_guess(pol, opc, disp, hint);
    seq = pc + 32'd4;
    tgt = pc + {{20{disp[11]}}, disp};
    npc = g ? tgt : seq;
    if (bv) begin
      chk(pred_taken == g, pol_tag(pol), "pred_taken", 32'(pred_taken), 32'(g));
      chk(pred_npc == npc, pol_tag(pol), "pred_npc", pred_npc, npc);
    end
    chk(fetch_stall == (bv && m_pend), "R6", "fetch_stall", 32'(fetch_stall),
        32'(bv && m_pend));
    chk(flush == m_flush, m_ftag, "flush", 32'(flush), 32'(m_flush));
    if (m_flush)
      chk(redirect_pc == m_redir, "R8", "redirect_pc", redirect_pc, m_redir);
    // model update for the coming edge
    m_flush = 1'b0;
    m_ftag  = "R7";
    if (rv && !m_pend) m_ftag = "R9";
    if (m_pend) begin
      if (rv) begin
        m_pend = 1'b0;
        if (rt != m_guess) begin
          m_flush = 1'b1;
          m_ftag  = "R8";
          m_redir = rt ? m_tgt : m_seq;
        end
      end
    end else if (bv) begin
      m_pend = 1'b1; m_guess = g; m_seq = seq; m_tgt = tgt;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    rst_n = 1'b0; br_valid = 0; br_pc = '0; br_opc = '0; br_disp = '0;
    br_hint = 0; policy_sel = 2'b00; res_valid = 0; res_taken = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(flush == 1'b0, "R1", "flush after reset", 32'(flush), 32'd0);
    chk(fetch_stall == 1'b0, "R1", "stall after reset", 32'(fetch_stall), 32'd0);

    // R9: strobe with nothing in flight
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 1, 1);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    // R2 guess not-taken, actually taken -> R8 redirect to target
    step(1, 2'b00, 32'h0000_1000, 3'd1, 12'h040, 0, 0, 0);
    // R6 second branch stalls, not recorded
    step(1, 2'b11, 32'h0000_5000, 3'd0, 12'h100, 1, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 1, 1);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    // R3 backward branch taken, actually not -> redirect to fall-through
    step(1, 2'b10, 32'h0000_2000, 3'd0, 12'hFF0, 0, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 1, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    // R4 opcode class 7 taken, confirmed -> R7 no flush
    step(1, 2'b01, 32'h0000_3000, 3'd7, 12'h010, 0, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 1, 1);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    // R5 hint, resolve and new branch in the same cycle (stall)
    step(1, 2'b11, 32'hFFFF_FFF0, 3'd3, 12'h7FC, 1, 0, 0);
    step(1, 2'b01, 32'h0000_4000, 3'd2, 12'h800, 0, 1, 0);
    step(1, 2'b01, 32'h0000_4000, 3'd2, 12'h800, 0, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 1, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rpc;
      rpc = {$urandom, 2'b00} ;
      step(($urandom % 3) != 0, 2'($urandom), rpc, 3'($urandom), 12'($urandom),
           1'($urandom), ($urandom % 3) == 0, 1'($urandom));
    end
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);
    step(0, 2'b00, 32'h0, 3'd0, 12'h0, 0, 0, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule